// File: doc/BRIEF.md
# Windowed Watchdog Reset Supervisor

This block generates the system reset for a processor. It combines three sources of reset: a power-on delay, a watchdog that checks the timing of software kicks against a window, and forced reset from supply monitoring. All timing is counted in ticks of a synchronous tick enable. The watchdog period `PERIOD_TICKS` sets every interval. The power-on hold lasts one period. The closed window lasts four fifths of a period and the open window lasts two fifths. The reset pulse on expiry lasts one fortieth of a period. `PERIOD_TICKS` must therefore be a multiple of 40.

Software kicks the watchdog with a falling edge on `wdg_kick`. A kick in the open window restarts the closed window and raises a one-cycle good strobe. A kick in the closed window pulses reset, just as a missed window does. After an expiry the reset output keeps pulsing with period closed + open + pulse until a kick lands inside an open window, or until a fresh power-up.

Two conditions force reset at once and restart the power-up sequence. The first is a loss of the digital "sense voltage OK" flag that lasts at least `DROP_TICKS` ticks. The second is the "supply over limit" flag. A one-cycle strobe marks every assertion of reset.

Top module: `wwdt_supervisor`

## Requirements
- R1: While `rst_n` is low, `sys_rst_n` is 0 and both `kick_good` and `rst_strobe` are 0.
- R2: Once `sense_ok` is high and `supply_over` is low, `sys_rst_n` stays low. One cycle is spent registering the flags, then the block holds reset for `PERIOD_TICKS` ticks before releasing it.
- R3: Falling edges on `wdg_kick` during the power-on hold have no effect: `kick_good` stays 0 and the hold length is unchanged.
- R4: After each restart the watchdog runs a closed window of 4·`PERIOD_TICKS`/5 ticks, then an open window of 2·`PERIOD_TICKS`/5 ticks. A kick recognised in the open window pulses `kick_good` high for one cycle and leaves reset released. It also starts a new closed window, so the next expiry comes closed + open ticks later. A kick taken on the last open tick still counts as a service.
- R5: A kick recognised in the closed window, the last closed tick included, pulls `sys_rst_n` low for `PERIOD_TICKS`/40 ticks. A new closed window then starts.
- R6: If the open window ends with no service, `sys_rst_n` goes low for `PERIOD_TICKS`/40 ticks and the window sequence repeats. This gives a high time of closed + open ticks and a low time of `PERIOD_TICKS`/40 ticks.
- R7: When `sense_ok` is low for `DROP_TICKS` consecutive ticks, `sys_rst_n` goes low on the following cycle and the power-on sequence restarts. A shorter dropout changes nothing.
- R8: A high `supply_over` pulls `sys_rst_n` low two cycles after it is applied and holds it there. When `supply_over` falls, the power-on hold of R2 runs again.
- R9: `rst_strobe` is high for exactly one cycle on each high-to-low transition of `sys_rst_n` and at no other time.
- R10: `wdg_kick` passes through two synchronizing flops. A falling edge is acted on at the third clock edge after the input changes, and one edge gives at most one service however long the input stays low.
- R11: Every interval advances only on cycles where `tick` is high. With a tick every second cycle, the power-on hold takes about twice as many cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| tick | input | 1 | Time-base enable, one clock wide per tick |
| sense_ok | input | 1 | Sense voltage above threshold (from external comparator) |
| supply_over | input | 1 | Supply above its upper limit |
| wdg_kick | input | 1 | Asynchronous watchdog clear, serviced on falling edge |
| sys_rst_n | output | 1 | Active-low system reset |
| kick_good | output | 1 | One-cycle strobe per accepted open-window service |
| rst_strobe | output | 1 | One-cycle strobe each time reset asserts |

## Verification
A window counter that is off by one tick shows up as a shifted boundary. A kick that should be accepted then pulses reset, or the other way round, within three cycles of the kick. It also shows as a high or low run on `sys_rst_n` whose length is one cycle wrong. The bench therefore sweeps the kick position across both window edges one cycle at a time, and measures each run of the reset output exactly. A wrong state after a fault is visible as a power-on hold of the wrong length, or as a missing or extra reset strobe within two cycles of the fault flag.

// File: rtl/wws_pkg.sv
package wws_pkg;
  typedef enum logic [2:0] {
    WS_DOWN   = 3'd0,
    WS_POR    = 3'd1,
    WS_CLOSED = 3'd2,
    WS_OPEN   = 3'd3,
    WS_PULSE  = 3'd4
  } wws_state_e;
endpackage

// File: rtl/wws_kick_sync.sv
// Two-flop synchronizer plus falling-edge detector for the watchdog kick.
module wws_kick_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_async,
  output logic kick_fall
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= kick_async;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign kick_fall = s3_q & ~s2_q;

  // R10: one input edge yields a single-cycle detect
  assert_one_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    kick_fall |=> !kick_fall);
endmodule

// File: rtl/wws_fault_qual.sv
// Qualifies loss of the sense flag over DROP_TICKS ticks and merges supply-over.
module wws_fault_qual #(
  parameter int DROP_TICKS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sense_ok,
  input  logic supply_over,
  output logic fault
);
  localparam int DW = $clog2(DROP_TICKS + 1);
  localparam logic [DW-1:0] D_LAST = DW'(DROP_TICKS - 1);

  logic          good_q, good_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic          fault_q, fault_d;

  always_comb begin
    good_d = good_q;
    cnt_d  = cnt_q;
    if (sense_ok) begin
      good_d = 1'b1;
      cnt_d  = '0;
    end else if (good_q && tick) begin
      if (cnt_q == D_LAST) begin
        good_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    fault_d = supply_over | ~good_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q  <= 1'b0;
      cnt_q   <= '0;
      fault_q <= 1'b1;
    end else begin
      good_q  <= good_d;
      cnt_q   <= cnt_d;
      fault_q <= fault_d;
    end
  end

  assign fault = fault_q;

  assert_drop_cnt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < DW'(DROP_TICKS));
  assert_supply_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    supply_over |=> fault);
endmodule

// File: rtl/wws_window_fsm.sv
// Power-on hold, closed/open window watchdog and expiry pulse sequencing.
module wws_window_fsm
  import wws_pkg::*;
#(
  parameter int PERIOD_TICKS = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic fault,
  input  logic kick_fall,
  output logic sys_rst_n,
  output logic kick_good,
  output logic rst_strobe
);
  localparam int CLOSED_TICKS = PERIOD_TICKS * 4 / 5;
  localparam int OPEN_TICKS   = PERIOD_TICKS * 2 / 5;
  localparam int PULSE_TICKS  = PERIOD_TICKS / 40;
  localparam int CW           = $clog2(PERIOD_TICKS);
  localparam logic [CW-1:0] P_LAST = CW'(PERIOD_TICKS - 1);
  localparam logic [CW-1:0] C_LAST = CW'(CLOSED_TICKS - 1);
  localparam logic [CW-1:0] O_LAST = CW'(OPEN_TICKS - 1);
  localparam logic [CW-1:0] W_LAST = CW'(PULSE_TICKS - 1);

  wws_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rel_q, rel_d;
  logic          good_q, good_d;
  logic          evt_q, evt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    good_d  = 1'b0;
    if (fault) begin
      state_d = WS_DOWN;
      cnt_d   = '0;
    end else begin
      case (state_q)
        WS_DOWN: begin
          state_d = WS_POR;
          cnt_d   = '0;
        end
        WS_POR: if (tick) begin
          if (cnt_q == P_LAST) begin
            state_d = WS_CLOSED;
            cnt_d   = '0;
          end else cnt_d = cnt_q + 1'b1;
        end
        WS_CLOSED: begin
          if (kick_fall) begin
            state_d = WS_PULSE;
            cnt_d   = '0;
          end else if (tick) begin
            if (cnt_q == C_LAST) begin
              state_d = WS_OPEN;
              cnt_d   = '0;
            end else cnt_d = cnt_q + 1'b1;
          end
        end
        WS_OPEN: begin
          if (kick_fall) begin
            state_d = WS_CLOSED;
            cnt_d   = '0;
            good_d  = 1'b1;
          end else if (tick) begin
            if (cnt_q == O_LAST) begin
              state_d = WS_PULSE;
              cnt_d   = '0;
            end else cnt_d = cnt_q + 1'b1;
          end
        end
        WS_PULSE: if (tick) begin
          if (cnt_q == W_LAST) begin
            state_d = WS_CLOSED;
            cnt_d   = '0;
          end else cnt_d = cnt_q + 1'b1;
        end
        default: begin
          state_d = WS_DOWN;
          cnt_d   = '0;
        end
      endcase
    end
    rel_d = (state_d == WS_CLOSED) || (state_d == WS_OPEN);
    evt_d = rel_q & ~rel_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WS_DOWN;
      cnt_q   <= '0;
      rel_q   <= 1'b0;
      good_q  <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rel_q   <= rel_d;
      good_q  <= good_d;
      evt_q   <= evt_d;
    end
  end

  assign sys_rst_n  = rel_q;
  assign kick_good  = good_q;
  assign rst_strobe = evt_q;

  assert_por_no_service_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WS_POR) |=> !kick_good);
  assert_service_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    kick_good |-> sys_rst_n);
  assert_pulse_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WS_PULSE) |-> (cnt_q <= W_LAST));
  assert_fault_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !sys_rst_n);
  assert_strobe_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_strobe |-> (!sys_rst_n && $past(sys_rst_n)));
endmodule

// File: rtl/wwdt_supervisor.sv
module wwdt_supervisor #(
  parameter int PERIOD_TICKS = 400,
  parameter int DROP_TICKS   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sense_ok,
  input  logic supply_over,
  input  logic wdg_kick,
  output logic sys_rst_n,
  output logic kick_good,
  output logic rst_strobe
);
  logic kick_fall;
  logic fault;

  wws_kick_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .kick_async (wdg_kick),
    .kick_fall  (kick_fall)
  );

  wws_fault_qual #(.DROP_TICKS(DROP_TICKS)) u_fault (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .sense_ok    (sense_ok),
    .supply_over (supply_over),
    .fault       (fault)
  );

  wws_window_fsm #(.PERIOD_TICKS(PERIOD_TICKS)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .fault      (fault),
    .kick_fall  (kick_fall),
    .sys_rst_n  (sys_rst_n),
    .kick_good  (kick_good),
    .rst_strobe (rst_strobe)
  );
endmodule

// File: tb/test_wwdt_supervisor.sv
module test_wwdt_supervisor;
  localparam int PT = 80;
  localparam int DT = 4;
  localparam int CL = PT * 4 / 5;
  localparam int OP = PT * 2 / 5;
  localparam int PW = PT / 40;

  logic clk = 1'b0;
  logic rst_n, tick, sense_ok, supply_over, wdg_kick;
  logic sys_rst_n, kick_good, rst_strobe;

  int vectors = 0, miscompares = 0;
  int cyc = 0, tick_div = 1;
  int svc_cnt = 0, evt_cnt = 0, fall_cnt = 0;
  logic prev_rel = 1'b0;

  always #5 clk = ~clk;

  wwdt_supervisor #(.PERIOD_TICKS(PT), .DROP_TICKS(DT)) i_wwdt_supervisor (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sense_ok(sense_ok),
    .supply_over(supply_over), .wdg_kick(wdg_kick),
    .sys_rst_n(sys_rst_n), .kick_good(kick_good), .rst_strobe(rst_strobe)
  );

  always @(negedge clk) begin
    cyc  = cyc + 1;
    tick = ((cyc % tick_div) == 0);
    if (rst_n) begin
      if (kick_good) svc_cnt = svc_cnt + 1;
      if (rst_strobe) evt_cnt = evt_cnt + 1;
      if (prev_rel && !sys_rst_n) fall_cnt = fall_cnt + 1;
    end
    prev_rel = sys_rst_n;
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic count_run(input logic lvl, output int n);
    n = 0;
    while (sys_rst_n === lvl && n < 20000) begin
      n++;
      step();
    end
  endtask

  // Drops the sense flag long enough to qualify, then raises it; returns
  // at the first sample with reset released.
  task automatic power_cycle();
    int n;
    sense_ok = 1'b0;
    repeat (DT + 3) step();
    sense_ok = 1'b1;
    step();
    count_run(1'b0, n);
    chk("R2 power-on hold cycles", n, PT + 1);
  endtask

  initial begin
    int n, s0, e0;
    rst_n = 1'b0; tick = 1'b1; sense_ok = 1'b1; supply_over = 1'b0; wdg_kick = 1'b1;
    repeat (3) step();
    chk("R1 reset output in reset", sys_rst_n, 0);
    chk("R1 good strobe in reset", kick_good, 0);
    chk("R1 reset strobe in reset", rst_strobe, 0);
    rst_n = 1'b1;
    step();
    count_run(1'b0, n);
    chk("R2 first power-on hold", n, PT + 1);

    // R6: free-running expiry square wave
    for (int r = 0; r < 2; r++) begin
      count_run(1'b1, n);
      chk("R6 high time closed+open", n, CL + OP);
      count_run(1'b0, n);
      chk("R6 expiry pulse width", n, PW);
    end

    // R4/R5/R10: kick position sweep across both window edges
    for (int k = CL - 4; k <= CL + OP - 2; k++) begin
      power_cycle();
      s0 = svc_cnt; e0 = evt_cnt;
      repeat (k) step();
      wdg_kick = 1'b0;
      repeat (3) step();
      if (k <= CL - 3) begin
        chk("R5 early kick reset strobe", evt_cnt - e0, 1);
        chk("R5 early kick no service", svc_cnt - s0, 0);
        count_run(1'b0, n);
        chk("R5 early kick pulse width", n, PW);
      end else if (k <= CL + OP - 3) begin
        chk("R4 open kick service strobe", svc_cnt - s0, 1);
        chk("R4 open kick no reset", evt_cnt - e0, 0);
        count_run(1'b1, n);
        chk("R4 next expiry after service", n, CL + OP);
        chk("R10 held kick single service", svc_cnt - s0, 1);
      end else begin
        chk("R6 late kick no service", svc_cnt - s0, 0);
        chk("R6 late kick expiry strobe", evt_cnt - e0, 1);
      end
      wdg_kick = 1'b1;
    end

    // R7: short dropout filtered, qualified dropout resets
    power_cycle();
    e0 = evt_cnt;
    sense_ok = 1'b0;
    repeat (DT - 1) step();
    sense_ok = 1'b1;
    repeat (3) step();
    chk("R7 short dropout keeps release", sys_rst_n, 1);
    chk("R7 short dropout no strobe", evt_cnt - e0, 0);
    sense_ok = 1'b0;
    repeat (DT) step();
    chk("R7 not yet reset at qualify edge", sys_rst_n, 1);
    step();
    chk("R7 qualified dropout resets", sys_rst_n, 0);
    chk("R9 dropout reset strobe", evt_cnt - e0, 1);
    sense_ok = 1'b1;
    step();
    count_run(1'b0, n);
    chk("R7 power-on restarts after dropout", n, PT + 1);

    // R8: supply over limit
    supply_over = 1'b1;
    step();
    chk("R8 one cycle after over-limit", sys_rst_n, 1);
    step();
    chk("R8 reset two cycles after over-limit", sys_rst_n, 0);
    repeat (5) step();
    chk("R8 reset held while over-limit", sys_rst_n, 0);
    supply_over = 1'b0;
    step();
    count_run(1'b0, n);
    chk("R8 power-on hold after release", n, PT + 1);

    // R3: kicks during the power-on hold are ignored
    sense_ok = 1'b0;
    repeat (DT + 3) step();
    sense_ok = 1'b1;
    s0 = svc_cnt;
    n = 0;
    for (int i = 0; i < 20000; i++) begin
      step();
      if (sys_rst_n) break;
      n++;
      if (i < 30) wdg_kick = ((i % 6) < 3) ? 1'b0 : 1'b1;
      else wdg_kick = 1'b1;
    end
    chk("R3 hold length with kicks", n, PT + 1);
    chk("R3 no service during hold", svc_cnt - s0, 0);

    // R11: tick every second cycle stretches the hold
    tick_div = 2;
    sense_ok = 1'b0;
    repeat (2 * DT + 4) step();
    sense_ok = 1'b1;
    step();
    count_run(1'b0, n);
    chk("R11 gated-tick hold in range", int'(n >= 2 * PT && n <= 2 * PT + 2), 1);
    tick_div = 1;

    chk("R9 one strobe per reset fall", evt_cnt, fall_cnt);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule